// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight asynchronous interrupt pins and turns each one into a latched pending request. Every pin has its own trigger type: falling edge, rising edge, either edge, low level or high level. A pending request reaches its own registered output only when two conditions hold. The pin's mask bit must be clear, and its 4-bit priority field must be nonzero. A combined output is raised when any per-pin output is high.

Software uses a small 32-bit register port with a write strobe, a read strobe and a 3-bit address. Trigger types and priority fields are held in two read-write words, with pin 0 in the top nibble. Pending flags are read from the low byte of the status word and are cleared by writing zeros to it. The mask is changed through two write-only words. One sets mask bits and the other clears them.

Top module: `ext_irq_pin_ctrl`

## Requirements
- R1: After a synchronous reset, every output is low. The trigger, priority and status words read as zero. Every pin is masked, so a pending pin stays silent until it is unmasked.
- R2: The trigger word (address 0) and the priority word (address 1) are read-write 32-bit registers. Pin n owns bits [(7-n)*4+3:(7-n)*4]. Read data appears on reg_rdata in the cycle after the read strobe and holds until the next read.
- R3: Trigger code 0 sets the pin's pending flag on a falling edge of the synchronised pin. Code 1 sets it on a rising edge, and code 4 sets it on either edge.
- R4: With trigger code 2 the pending flag follows the synchronised pin being low. With code 3 it follows the pin being high. Writing zero to the status word cannot clear it while the level stays active.
- R5: Trigger codes 5 to 15 never set a pending flag, whatever the pin does.
- R6: Reading the status word (address 2) returns pin n's pending flag at bit 7-n. Bits 31:8 read as zero.
- R7: Writing the status word clears pin n's pending flag (in the edge and disabled codes) when bit 7-n is 0. A 1 in bit 7-n leaves the flag as it is. If a new edge arrives in the same cycle, the edge wins.
- R8: A 1 at bit 7-n of a write to address 3 masks pin n. A 1 at bit 7-n of a write to address 4 unmasks it. Zero bits have no effect. Both addresses read as zero. Masking hides the output but keeps the pending flag.
- R9: A priority field of zero blocks that pin's output even while it is pending and unmasked. Any nonzero field lets it through.
- R10: irq_pin_o[n] is registered and equals the previous cycle's pending AND not-masked AND priority-nonzero for pin n. irq_any_o is high exactly when some irq_pin_o bit is high.
- R11: With the default two synchroniser stages, a pin change sampled at clock edge k sets the pending flag at edge k+2. The output changes at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous interrupt pins, bit n is pin n |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address (0 trigger, 1 priority, 2 status, 3 mask set, 4 mask clear) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_pin_o | output | NUM_PINS | Per-pin gated interrupt, bit n is pin n |
| irq_any_o | output | 1 | OR of all per-pin interrupts |

## Verification
The assertions check four rules on every cycle. The combined output always matches the OR of the per-pin outputs. A mask-set write silences the named pin two cycles later, and so does a write of a zero priority field. The write-only mask words and the upper status bits always read back as zero. What only the bench scenarios can show is the behaviour that depends on pin history and trigger type: edge versus level capture, the exact three-cycle latency, level flags surviving a write-zero clear, and disabled codes ignoring pin activity. A behavioural reference model checks all of this cycle by cycle.

// File: rtl/eip_pkg.sv
package eip_pkg;
  localparam int MAX_PINS = 8;
  localparam int FIELD_W  = 4;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] A_TRIG = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRIO = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_MSET = 3'd3;
  localparam logic [ADDR_W-1:0] A_MCLR = 3'd4;

  typedef enum logic [FIELD_W-1:0] {
    TRIG_FALL = 4'd0,
    TRIG_RISE = 4'd1,
    TRIG_LOW  = 4'd2,
    TRIG_HIGH = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_e;
endpackage

// File: rtl/eip_sync.sv
module eip_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eip_pin_cell.sv
module eip_pin_cell
  import eip_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               lvl,
  input  logic [FIELD_W-1:0] mode,
  input  logic               clr_req,
  output logic               pend
);
  logic prev;
  logic rise, fall, set_ev, is_level, lvl_active;

  always_comb begin
    rise       = lvl & ~prev;
    fall       = ~lvl & prev;
    set_ev     = 1'b0;
    is_level   = 1'b0;
    lvl_active = 1'b0;
    case (mode)
      TRIG_FALL: set_ev = fall;
      TRIG_RISE: set_ev = rise;
      TRIG_BOTH: set_ev = rise | fall;
      TRIG_LOW: begin
        is_level   = 1'b1;
        lvl_active = ~lvl;
      end
      TRIG_HIGH: begin
        is_level   = 1'b1;
        lvl_active = lvl;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      prev <= lvl;
      if (is_level)     pend <= lvl_active;
      else if (set_ev)  pend <= 1'b1;
      else if (clr_req) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/eip_regs.sv
module eip_regs
  import eip_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  input  logic [NUM_PINS-1:0] pend,
  output logic [REG_W-1:0]    rdata,
  output logic [REG_W-1:0]    trig_q,
  output logic [REG_W-1:0]    prio_q,
  output logic [NUM_PINS-1:0] mask_q,
  output logic [NUM_PINS-1:0] clr_req
);
  localparam int TOP = MAX_PINS - 1;

  logic [NUM_PINS-1:0] wbits;
  logic [MAX_PINS-1:0] stat_view;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_map
    assign wbits[n] = wdata[TOP-n];
  end

  always_comb begin
    stat_view = '0;
    for (int n = 0; n < NUM_PINS; n++) stat_view[TOP-n] = pend[n];
  end

  assign clr_req = {NUM_PINS{wr_en && (addr == A_STAT)}} & ~wbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= '0;
      prio_q <= '0;
      mask_q <= '1;
    end else if (wr_en) begin
      case (addr)
        A_TRIG:  trig_q <= wdata;
        A_PRIO:  prio_q <= wdata;
        A_MSET:  mask_q <= mask_q | wbits;
        A_MCLR:  mask_q <= mask_q & ~wbits;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        A_TRIG:  rdata <= trig_q;
        A_PRIO:  rdata <= prio_q;
        A_STAT:  rdata <= {{(REG_W-MAX_PINS){1'b0}}, stat_view};
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ext_irq_pin_ctrl.sv
module ext_irq_pin_ctrl
  import eip_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_wr_en,
  input  logic                reg_rd_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [NUM_PINS-1:0] irq_pin_o,
  output logic                irq_any_o
);
  localparam int TOP = MAX_PINS - 1;

  logic [NUM_PINS-1:0] pin_s;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] clr_req;
  logic [NUM_PINS-1:0] req_next;
  logic [REG_W-1:0]    trig_q;
  logic [REG_W-1:0]    prio_q;

  eip_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_i),
    .q   (pin_s)
  );

  eip_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .rd_en   (reg_rd_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .pend    (pend),
    .rdata   (reg_rdata),
    .trig_q  (trig_q),
    .prio_q  (prio_q),
    .mask_q  (mask_q),
    .clr_req (clr_req)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    eip_pin_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .lvl     (pin_s[n]),
      .mode    (trig_q[(TOP-n)*FIELD_W +: FIELD_W]),
      .clr_req (clr_req[n]),
      .pend    (pend[n])
    );
    assign req_next[n] = pend[n] & ~mask_q[n] & (|prio_q[(TOP-n)*FIELD_W +: FIELD_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pin_o <= '0;
      irq_any_o <= 1'b0;
    end else begin
      irq_pin_o <= req_next;
      irq_any_o <= |req_next;
    end
  end
endmodule

// File: rtl/eip_checker.sv
module eip_checker
  import eip_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_wr_en,
  input logic                reg_rd_en,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [REG_W-1:0]    reg_wdata,
  input logic [REG_W-1:0]    reg_rdata,
  input logic [NUM_PINS-1:0] irq_pin_o,
  input logic                irq_any_o
);
  localparam int TOP = MAX_PINS - 1;

  AST_ANY_FOLLOWS_PINS: assert property (@(posedge clk) disable iff (rst)
    irq_any_o == (|irq_pin_o)); // R10

  AST_WRITEONLY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd_en && (reg_addr == A_MSET || reg_addr == A_MCLR)) |-> reg_rdata == '0); // R8

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd_en && reg_addr == A_STAT) |-> reg_rdata[REG_W-1:MAX_PINS] == '0); // R6

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
    logic mset_hit, prio_zero_hit;
    assign mset_hit      = reg_wr_en && (reg_addr == A_MSET) && reg_wdata[TOP-n];
    assign prio_zero_hit = reg_wr_en && (reg_addr == A_PRIO) &&
                           (reg_wdata[(TOP-n)*FIELD_W +: FIELD_W] == '0);

    AST_MASKSET_SILENCES: assert property (@(posedge clk) disable iff (rst)
      $past(mset_hit, 2) |-> !irq_pin_o[n]); // R8

    AST_PRIO_ZERO_SILENCES: assert property (@(posedge clk) disable iff (rst)
      $past(prio_zero_hit, 2) |-> !irq_pin_o[n]); // R9
  end
endmodule

bind ext_irq_pin_ctrl eip_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_pin_o (irq_pin_o),
  .irq_any_o (irq_any_o)
);

// File: tb/ext_irq_pin_ctrl_test.sv
module ext_irq_pin_ctrl_test;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] irq_pin_o;
  logic          irq_any_o;

  always #4 clk = ~clk;

  ext_irq_pin_ctrl #(.NUM_PINS(NP)) uut (
    .clk       (clk),
    .rst       (rst),
    .pin_i     (pins),
    .reg_wr_en (wr),
    .reg_rd_en (rd),
    .reg_addr  (addr),
    .reg_wdata (wdata),
    .reg_rdata (reg_rdata),
    .irq_pin_o (irq_pin_o),
    .irq_any_o (irq_any_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Behavioural reference model
  logic [7:0]    hist[$] = '{8'h0, 8'h0, 8'h0, 8'h0};
  bit [NP-1:0]   m_pend, m_mask = '1, m_out, new_out;
  bit            m_any, m_rd_flag, ev;
  bit [31:0]     m_trig, m_prio, m_rdata;
  bit [7:0]      cur, old;
  int            code;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{8'h0, 8'h0, 8'h0, 8'h0};
      m_pend = '0; m_mask = '1; m_out = '0; m_any = 0;
      m_trig = '0; m_prio = '0; m_rdata = '0; m_rd_flag = 0;
    end else begin
      hist.push_front(pins);
      void'(hist.pop_back());
      cur = hist[2];
      old = hist[3];
      for (int n = 0; n < NP; n++)
        new_out[n] = m_pend[n] && !m_mask[n] && (m_prio[(7-n)*4 +: 4] != 0);
      if (rd) begin
        if (addr == 0)      m_rdata = m_trig;
        else if (addr == 1) m_rdata = m_prio;
        else if (addr == 2) begin
          m_rdata = '0;
          for (int n = 0; n < NP; n++) m_rdata[7-n] = m_pend[n];
        end else m_rdata = '0;
      end
      m_rd_flag = rd;
      for (int n = 0; n < NP; n++) begin
        code = int'(m_trig[(7-n)*4 +: 4]);
        if (code == 2)      m_pend[n] = !cur[n];
        else if (code == 3) m_pend[n] = cur[n];
        else begin
          ev = (code == 0 && old[n] && !cur[n]) || (code == 1 && !old[n] && cur[n]) ||
               (code == 4 && old[n] != cur[n]);
          if (ev) m_pend[n] = 1;
          else if (wr && addr == 2 && !wdata[7-n]) m_pend[n] = 0;
        end
      end
      if (wr) begin
        if (addr == 0) m_trig = wdata;
        if (addr == 1) m_prio = wdata;
        for (int n = 0; n < NP; n++) begin
          if (addr == 3 && wdata[7-n]) m_mask[n] = 1;
          if (addr == 4 && wdata[7-n]) m_mask[n] = 0;
        end
      end
      m_out = new_out;
      m_any = |new_out;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R10 per-pin outputs vs model", {24'h0, irq_pin_o}, {24'h0, m_out});
      check("R10 combined output vs model", {31'h0, irq_any_o}, {31'h0, m_any});
      if (m_rd_flag) check("R2 R6 read data vs model", reg_rdata, m_rdata);
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset per-pin outputs", {24'h0, irq_pin_o}, 32'h0);
    check("R1 reset combined output", {31'h0, irq_any_o}, 32'h0);
    rd_reg(0, v); check("R1 reset trigger word", v, 32'h0);
    rd_reg(1, v); check("R1 reset priority word", v, 32'h0);
    rd_reg(2, v); check("R1 reset status word", v, 32'h0);

    // pins 0..7: rise, fall, low, high, both, code7, rise, rise
    wr_reg(0, 32'h1023_4711);
    rd_reg(0, v); check("R2 trigger readback", v, 32'h1023_4711);
    wr_reg(1, 32'hFFFF_FFF0);
    rd_reg(1, v); check("R2 priority readback", v, 32'hFFFF_FFF0);
    idle(4);
    check("R1 masked pin stays silent", {24'h0, irq_pin_o}, 32'h0);
    rd_reg(2, v); check("R4 low level pending", v, 32'h20);

    wr_reg(4, 32'hFF);
    idle(2);
    check("R8 unmask exposes pin2", {24'h0, irq_pin_o}, 32'h04);
    rd_reg(3, v); check("R8 mask-set reads zero", v, 32'h0);
    rd_reg(4, v); check("R8 mask-clear reads zero", v, 32'h0);

    @(negedge clk); pins[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 output not yet raised", {31'h0, irq_pin_o[0]}, 32'h0);
    @(negedge clk);
    check("R11 R3 rising edge raises output", {31'h0, irq_pin_o[0]}, 32'h1);
    rd_reg(2, v); check("R6 status bit order", v, 32'hA0);

    wr_reg(2, 32'h7F);
    rd_reg(2, v); check("R7 zero clears only pin0", v, 32'h20);
    wr_reg(2, 32'h0);
    rd_reg(2, v); check("R4 level flag survives clear", v, 32'h20);

    @(negedge clk); pins[5] = 1'b1; idle(4); pins[5] = 1'b0; idle(5);
    rd_reg(2, v); check("R5 disabled code ignores pin", v, 32'h20);

    @(negedge clk); pins[4] = 1'b1; idle(5);
    rd_reg(2, v); check("R3 both-edge on rise", v, 32'h28);
    wr_reg(2, 32'hF7);
    rd_reg(2, v); check("R7 clear pin4", v, 32'h20);
    @(negedge clk); pins[4] = 1'b0; idle(5);
    rd_reg(2, v); check("R3 both-edge on fall", v, 32'h28);

    @(negedge clk); pins[1] = 1'b1; idle(5);
    rd_reg(2, v); check("R3 falling mode ignores rise", v, 32'h28);
    @(negedge clk); pins[1] = 1'b0; idle(5);
    rd_reg(2, v); check("R3 falling edge captured", v, 32'h68);

    @(negedge clk); pins[7] = 1'b1; idle(5);
    rd_reg(2, v); check("R9 pending under zero priority", v, 32'h69);
    check("R9 zero priority blocks output", {31'h0, irq_pin_o[7]}, 32'h0);
    wr_reg(1, 32'hFFFF_FFFF); idle(2);
    check("R9 nonzero priority passes output", {31'h0, irq_pin_o[7]}, 32'h1);

    wr_reg(3, 32'h08); idle(2);
    check("R8 mask-set hides pin4", {31'h0, irq_pin_o[4]}, 32'h0);
    rd_reg(2, v); check("R8 masked pin keeps pending", v, 32'h69);
    wr_reg(3, 32'h0); idle(2);
    check("R8 zero mask-set write no effect", {31'h0, irq_pin_o[1]}, 32'h1);
    check("R10 combined high", {31'h0, irq_any_o}, 32'h1);

    wr_reg(0, 32'hFFFF_FFFF);
    rd_reg(0, v); check("R2 trigger all ones", v, 32'hFFFF_FFFF);
    wr_reg(2, 32'h0); idle(2);
    check("R7 clear-all empties outputs", {24'h0, irq_pin_o}, 32'h0);
    check("R10 combined low", {31'h0, irq_any_o}, 32'h0);
    @(negedge clk); pins = 8'h00; idle(5);
    rd_reg(2, v); check("R5 disabled codes stay clear", v, 32'h0);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end
endmodule